// File: doc/BRIEF.md
# Interrupt CPU-Target Register Bank

This block sits inside an interrupt distributor. It holds, for every implemented interrupt line, an 8-bit mask that names the processors allowed to receive that interrupt: bit n of the mask selects processor n. The fields are packed four to a 32-bit word, so interrupt i lives in byte lane i mod 4 of the word at byte offset 0x800 + i within the distributor's 4 KiB register space.

Software reaches the fields through a simple register bus. A write strobe or a read strobe qualifies a 12-bit byte address, and four byte enables choose the lanes, which allows whole-word and single-byte access. The low two address bits do not select lanes; the byte enables do. Two build-time parameters set the processor count (1 to 8) and the interrupt count (a multiple of 32). Mask bits for processors that are not built always read as zero, and any access that falls past the last implemented interrupt reads zero and changes nothing. The routing logic next to the bank reads every interrupt's current mask from a flat output vector without using the bus.

Top module: `irq_tgt_bank`

## Requirements
- R1: While reset is high, and in the cycle after it falls, every target field is zero and the read data output is zero.
- R2: A write with all four byte enables set, followed by a read of the same word, returns the written data ANDed in every byte with (1 << NUM_CPUS) - 1.
- R3: Mask bits at or above bit NUM_CPUS in any byte read as zero and cannot be set; writing 0xFFFFFFFF to a word reads back as the processor mask repeated in all four lanes.
- R4: A write with only some byte enables set changes only the enabled lanes (be[k] covers data bits 8k+7..8k); the other fields of that word keep their values.
- R5: A read returns the addressed word's enabled lanes in their own bit positions and zero in every lane whose byte enable is clear.
- R6: An access whose byte address is below 0x800 or at or above 0x800 + NUM_IRQS reads as zero one cycle later and leaves every target field unchanged.
- R7: Read data appears on the output in the cycle after the read strobe is sampled and is zero in any cycle that follows a cycle with no read strobe.
- R8: Byte i of the target output vector equals the field of interrupt i, and it changes only in the cycle after an in-range write that enables that field's lane.
- R9: A read and a write to the same word in the same cycle return the contents the word had before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_rd | input | 1 | Read strobe, sampled on the clock edge |
| bus_addr | input | 12 | Byte address within the distributor space |
| bus_be | input | 4 | Byte enables, bit k selects data lane k |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tgt_mask_o | output | NUM_IRQS*8 | Target mask of every interrupt, interrupt i in bits 8i+7..8i |

## Verification
The assertions take the bus to be well formed: strobes and byte enables are clean levels each cycle, and a read's result is judged only by the strobe and enables sampled one edge earlier. They also assume the address range check alone decides whether an access lands, with no dependence on the low two address bits beyond that comparison. The stimulus changes bus inputs only on the falling edge, holds each strobe for exactly one rising edge, and returns the enables to zero between accesses, so every sampled access is one the properties describe.

// File: rtl/irq_tgt_pkg.sv
package irq_tgt_pkg;

    localparam int ADDR_W  = 12;
    localparam int LANES   = 4;
    localparam int FIELD_W = 8;
    localparam int WORD_W  = LANES * FIELD_W;
    localparam int MAX_CPUS = FIELD_W;
    localparam int WIDX_W  = 8;

    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [LANES-1:0]   lane_en_t;
    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [FIELD_W-1:0] field_t;
    typedef logic [WIDX_W-1:0]  widx_t;

    typedef struct packed {
        logic     wr;
        logic     rd;
        addr_t    addr;
        lane_en_t be;
        word_t    wdata;
    } bus_req_t;

    typedef struct packed {
        logic     hit;
        widx_t    widx;
        lane_en_t be;
    } decode_t;

    function automatic field_t cpu_field_mask(int ncpu);
        field_t m;
        for (int b = 0; b < FIELD_W; b++) begin
            m[b] = (b < ncpu);
        end
        return m;
    endfunction

    function automatic word_t cpu_word_mask(int ncpu);
        word_t m;
        for (int l = 0; l < LANES; l++) begin
            m[l*FIELD_W +: FIELD_W] = cpu_field_mask(ncpu);
        end
        return m;
    endfunction

    function automatic word_t lane_bits(lane_en_t be);
        word_t m;
        for (int l = 0; l < LANES; l++) begin
            m[l*FIELD_W +: FIELD_W] = {FIELD_W{be[l]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_tgt_decode.sv
module irq_tgt_decode
    import irq_tgt_pkg::*;
#(
    parameter int    NUM_IRQS = 64,
    parameter addr_t TGT_BASE = 12'h800
) (
    input  bus_req_t req,
    output decode_t  dec
);
    localparam int REGION_BYTES = (1 << WIDX_W) * LANES;

    logic  above_base;
    addr_t offset;
    logic  below_limit;

    always_comb begin
        above_base  = (req.addr >= TGT_BASE);
        offset      = req.addr - TGT_BASE;
        below_limit = (int'(offset) < NUM_IRQS) && (int'(offset) < REGION_BYTES);
        dec.hit     = above_base && below_limit;
        dec.widx    = offset[WIDX_W+1:2];
        dec.be      = req.be;
    end

endmodule

// File: rtl/irq_tgt_store.sv
module irq_tgt_store
    import irq_tgt_pkg::*;
#(
    parameter int NUM_CPUS = 4,
    parameter int NUM_IRQS = 64
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  widx_t                       widx,
    input  lane_en_t                    be,
    input  word_t                       wdata,
    output word_t                       rd_word,
    output logic [NUM_IRQS*FIELD_W-1:0] fields_o
);
    localparam int NWORDS = NUM_IRQS / LANES;

    word_t words [NWORDS];

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        logic sel;
        assign sel = wr_en && (widx == widx_t'(w));

        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [NUM_CPUS-1:0] bits_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    bits_q <= '0;
                end else if (sel && be[l]) begin
                    bits_q <= wdata[l*FIELD_W +: NUM_CPUS];
                end
            end

            if (NUM_CPUS < FIELD_W) begin : g_pad
                assign words[w][l*FIELD_W +: FIELD_W] =
                    {{(FIELD_W-NUM_CPUS){1'b0}}, bits_q};
            end else begin : g_full
                assign words[w][l*FIELD_W +: FIELD_W] = bits_q;
            end

            assign fields_o[(w*LANES+l)*FIELD_W +: FIELD_W] =
                words[w][l*FIELD_W +: FIELD_W];
        end
    end

    always_comb begin
        rd_word = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (widx == widx_t'(w)) begin
                rd_word = words[w];
            end
        end
    end

endmodule

// File: rtl/irq_tgt_rdport.sv
module irq_tgt_rdport
    import irq_tgt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     rd_en,
    input  logic     hit,
    input  lane_en_t be,
    input  word_t    word_in,
    output word_t    rdata
);
    word_t next_q;

    always_comb begin
        if (rd_en && hit) begin
            next_q = word_in & lane_bits(be);
        end else begin
            next_q = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else begin
            rdata <= next_q;
        end
    end

endmodule

// File: rtl/irq_tgt_bank.sv
module irq_tgt_bank
    import irq_tgt_pkg::*;
#(
    parameter int    NUM_CPUS = 4,
    parameter int    NUM_IRQS = 64,
    parameter addr_t TGT_BASE = 12'h800
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    input  logic [11:0]                  bus_addr,
    input  logic [3:0]                   bus_be,
    input  logic [31:0]                  bus_wdata,
    output logic [31:0]                  bus_rdata,
    output logic [NUM_IRQS*8-1:0]        tgt_mask_o
);
    bus_req_t req;
    decode_t  dec;
    word_t    stored_word;

    assign req = '{wr: bus_wr, rd: bus_rd, addr: bus_addr,
                   be: bus_be, wdata: bus_wdata};

    irq_tgt_decode #(
        .NUM_IRQS (NUM_IRQS),
        .TGT_BASE (TGT_BASE)
    ) u_decode (
        .req (req),
        .dec (dec)
    );

    irq_tgt_store #(
        .NUM_CPUS (NUM_CPUS),
        .NUM_IRQS (NUM_IRQS)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (req.wr && dec.hit),
        .widx     (dec.widx),
        .be       (dec.be),
        .wdata    (req.wdata),
        .rd_word  (stored_word),
        .fields_o (tgt_mask_o)
    );

    irq_tgt_rdport u_rdport (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (req.rd),
        .hit     (dec.hit),
        .be      (dec.be),
        .word_in (stored_word),
        .rdata   (bus_rdata)
    );

endmodule

// File: rtl/irq_tgt_bank_chk.sv
module irq_tgt_bank_chk
    import irq_tgt_pkg::*;
#(
    parameter int    NUM_CPUS = 4,
    parameter int    NUM_IRQS = 64,
    parameter addr_t TGT_BASE = 12'h800
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic [11:0]           bus_addr,
    input logic [3:0]            bus_be,
    input logic [31:0]           bus_rdata,
    input logic [NUM_IRQS*8-1:0] tgt_mask_o
);
    localparam logic [NUM_IRQS*8-1:0] ALL_MASK = {(NUM_IRQS/4){cpu_word_mask(NUM_CPUS)}};

    logic in_range;
    assign in_range = (int'(bus_addr) >= int'(TGT_BASE)) &&
                      (int'(bus_addr) <  int'(TGT_BASE) + NUM_IRQS);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (bus_rdata == '0) && (tgt_mask_o == '0)); // R1

    AST_NO_PHANTOM_CPU: assert property (@(posedge clk) disable iff (rst)
        ((tgt_mask_o & ~ALL_MASK) == '0) &&
        ((bus_rdata & ~cpu_word_mask(NUM_CPUS)) == '0)); // R3

    AST_OOR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !in_range) |=> $stable(tgt_mask_o)); // R6

    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !in_range) |=> (bus_rdata == '0)); // R6

    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == '0)); // R7

    AST_DISABLED_LANE_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> ((bus_rdata & ~lane_bits($past(bus_be))) == '0)); // R5

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(tgt_mask_o)); // R8

endmodule

bind irq_tgt_bank irq_tgt_bank_chk #(
    .NUM_CPUS (NUM_CPUS),
    .NUM_IRQS (NUM_IRQS),
    .TGT_BASE (TGT_BASE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_be     (bus_be),
    .bus_rdata  (bus_rdata),
    .tgt_mask_o (tgt_mask_o)
);

// File: tb/irq_tgt_bank_bench.sv
module irq_tgt_bank_bench;
    localparam int NC = 3;
    localparam int NI = 32;
    localparam int NW = NI / 4;
    localparam logic [11:0] BASE = 12'h800;
    localparam logic [7:0]  CM   = 8'((1 << NC) - 1);

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic               rst = 1'b1;
    logic               bus_wr = 1'b0;
    logic               bus_rd = 1'b0;
    logic [11:0]        bus_addr = '0;
    logic [3:0]         bus_be = '0;
    logic [31:0]        bus_wdata = '0;
    logic [31:0]        bus_rdata;
    logic [NI*8-1:0]    tgt_mask_o;

    irq_tgt_bank #(.NUM_CPUS(NC), .NUM_IRQS(NI), .TGT_BASE(BASE)) u_irq_tgt_bank (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .tgt_mask_o(tgt_mask_o)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [7:0] model [NI];

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(int w, logic [3:0] be);
        logic [31:0] r = '0;
        for (int l = 0; l < 4; l++) if (be[l]) r[l*8 +: 8] = model[w*4+l];
        return r;
    endfunction

    task automatic check_fields(string req);
        for (int i = 0; i < NI; i++) chk(req, {24'h0, tgt_mask_o[i*8 +: 8]}, {24'h0, model[i]});
    endtask

    task automatic bus_write(logic [11:0] a, logic [3:0] be, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic bus_read(logic [11:0] a, logic [3:0] be, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a; bus_be = be;
        @(negedge clk);
        bus_rd = 1'b0; bus_be = '0;
        d = bus_rdata;
    endtask

    function automatic void model_write(int w, logic [3:0] be, logic [31:0] d);
        for (int l = 0; l < 4; l++) if (be[l]) model[w*4+l] = d[l*8 +: 8] & CM;
    endfunction

    initial begin
        #1000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] old;
        for (int i = 0; i < NI; i++) model[i] = '0;

        repeat (3) @(negedge clk);
        chk("R1 rdata in reset", bus_rdata, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 rdata after reset", bus_rdata, 32'h0);
        check_fields("R1 field after reset");
        for (int w = 0; w < NW; w++) begin
            bus_read(BASE + 12'(w*4), 4'hF, rd);
            chk("R1 word after reset", rd, 32'h0);
        end

        // R3: all ones leave only the implemented processor bits
        bus_write(BASE, 4'hF, 32'hFFFF_FFFF);
        model_write(0, 4'hF, 32'hFFFF_FFFF);
        bus_read(BASE, 4'hF, rd);
        chk("R3 all-ones readback", rd, {4{CM}});

        // R2 / R8: whole-word sweep
        for (int w = 0; w < NW; w++) begin
            logic [31:0] d = 32'h0103_020F ^ (32'(w) * 32'h1B2D_3C4F);
            bus_write(BASE + 12'(w*4), 4'hF, d);
            model_write(w, 4'hF, d);
            check_fields("R8 field after word write");
        end
        for (int w = 0; w < NW; w++) begin
            bus_read(BASE + 12'(w*4), 4'hF, rd);
            chk("R2 word readback", rd, exp_word(w, 4'hF));
        end

        // R4: single-lane writes
        for (int w = 0; w < NW; w++) begin
            for (int l = 0; l < 4; l++) begin
                logic [31:0] d = {4{8'(8'h55 + w + l*3)}};
                bus_write(BASE + 12'(w*4 + l), 4'(1 << l), d);
                model_write(w, 4'(1 << l), d);
                bus_read(BASE + 12'(w*4), 4'hF, rd);
                chk("R4 lane write", rd, exp_word(w, 4'hF));
            end
        end
        check_fields("R8 field after lane writes");

        // R5: every byte-enable pattern on every word
        for (int w = 0; w < NW; w++) begin
            for (int be = 1; be < 16; be++) begin
                bus_read(BASE + 12'(w*4), 4'(be), rd);
                chk("R5 lane read", rd, exp_word(w, 4'(be)));
            end
        end

        // R6: outside the implemented range
        begin
            logic [11:0] oor [6] = '{BASE + 12'(NI), BASE + 12'(NI + 4),
                                     12'hBFC, 12'h7FC, 12'h000, 12'hFFC};
            for (int k = 0; k < 6; k++) begin
                bus_write(oor[k], 4'hF, 32'hFFFF_FFFF);
                check_fields("R6 write ignored");
                bus_read(oor[k], 4'hF, rd);
                chk("R6 read zero", rd, 32'h0);
            end
        end

        // R7: data present for one cycle only
        bus_read(BASE + 12'h4, 4'hF, rd);
        chk("R7 read latency", rd, exp_word(1, 4'hF));
        @(negedge clk);
        chk("R7 idle rdata", bus_rdata, 32'h0);

        // R9: read and write of the same word together
        old = exp_word(2, 4'hF);
        @(negedge clk);
        bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = BASE + 12'h8;
        bus_be = 4'hF; bus_wdata = 32'h0506_0102;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; bus_be = '0;
        chk("R9 read sees old data", bus_rdata, old);
        model_write(2, 4'hF, 32'h0506_0102);
        bus_read(BASE + 12'h8, 4'hF, rd);
        chk("R9 new data afterwards", rd, exp_word(2, 4'hF));

        // R1: reset again clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NI; i++) model[i] = '0;
        check_fields("R1 field after second reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule